// File: doc/BRIEF.md
# Real-Time Clock With Compare Alarms

This block keeps time as a seconds count and a sub-second count. It is fed by a slow reference clock that is free-running and unrelated to the bus clock. A two-stage synchronizer and an edge detector turn each rising edge of the slow clock into a one-cycle tick. A fractional accumulator then converts those ticks into sub-second steps. The live counters sit in the bus clock domain. Software does not read them directly. It reads a published copy, which is refreshed once every `COPY_TICKS` ticks. A busy window of `COPY_CYC` bus cycles opens at each refresh.

Requests arrive on a valid/ready port. Reads are always accepted. A write that arrives while the busy window is open sees `req_ready_o` low and must hold its valid, address and data until ready returns. No write is dropped. Each accepted read produces one registered response on `rsp_valid_o`/`rsp_rdata_o`; the response channel has no back-pressure. A read of the sub-second register also freezes the published seconds into a separate snapshot register, so that both halves of a time stamp belong together.

Five event sources feed a sticky status word: two seconds comparators, one sub-second comparator and two external countdown strobes. Status bits are cleared by writing 1. A mask word gates the status bits onto a level-high interrupt.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset, the live and published counters, the snapshot, both seconds compare values, the sub-second compare value, the mask and the status all read 0. The busy window is closed and `irq_o` is low.
- R2: Offset 0x04 bit 0 reads 1 for exactly `COPY_CYC` cycles after every `COPY_TICKS`-th synchronized tick. At that tick, seconds (0x08) and sub-seconds (0x10) take the live values; between copies they hold.
- R3: A read request is accepted in the cycle it is presented. A write request sees `req_ready_o` low while busy is 1, and it takes effect in the cycle it is finally accepted.
- R4: An accepted read of 0x10 loads the published seconds value into the snapshot register at 0x0C, which then holds until the next such read.
- R5: Each synchronized tick adds `MS_PER_SEC` to an accumulator. When the sum reaches `TICKS_PER_SEC`, that amount is subtracted and the sub-second count steps. The step from `MS_PER_SEC-1` goes to 0 and adds one second.
- R6: A write to 0x08 sets the live and published seconds at once. Counting continues from the written value, and a carry in the same cycle is overridden by the write.
- R7: Status bit 0 (compare at 0x14) and status bit 1 (compare at 0x18) set when a sub-second wrap carries the seconds onto the compare value. A compare value of 0 never sets its bit, including on a roll-over to 0.
- R8: Status bit 2 sets when the sub-second count steps onto the value at 0x1C; a value of 0 never sets it.
- R9: A one-cycle pulse on `cdn_sec_i` sets status bit 3, and one on `cdn_ms_i` sets status bit 4.
- R10: Writing status (0x2C) clears each bit written as 1 and leaves bits written as 0. A source that sets a bit in the same cycle wins over the clear.
- R11: Status bits set whether or not they are masked. `irq_o` is high exactly while some bit is set in both status and mask (0x28, same bit layout).
- R12: `rsp_valid_o` is high in the cycle after each accepted read and only then. Reads of unmapped offsets return 0, and writes to unmapped or read-only offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk_i | input | 1 | Slow reference clock, asynchronous to clk |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| cdn_sec_i | input | 1 | Seconds countdown expiry strobe |
| cdn_ms_i | input | 1 | Sub-second countdown expiry strobe |
| irq_o | output | 1 | Level-high interrupt |

## Verification
The bench builds the block with `TICKS_PER_SEC`=40, `MS_PER_SEC`=10, `COPY_TICKS`=8 and `COPY_CYC`=3, and a slow clock of four bus cycles. One second then takes 160 bus cycles, so many copy windows, sub-second wraps, seconds compare hits and a 32-bit seconds roll-over fit into a short run. Writes collide with open busy windows often enough to exercise the held-request path. The per-cycle reference model checks every response, ready and interrupt value.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W = 32;
  localparam int NSRC   = 5;

  localparam logic [7:0] OFF_BUSY   = 8'h04;
  localparam logic [7:0] OFF_SEC    = 8'h08;
  localparam logic [7:0] OFF_SNAP   = 8'h0C;
  localparam logic [7:0] OFF_MS     = 8'h10;
  localparam logic [7:0] OFF_CMP0   = 8'h14;
  localparam logic [7:0] OFF_CMP1   = 8'h18;
  localparam logic [7:0] OFF_CMPMS  = 8'h1C;
  localparam logic [7:0] OFF_MASK   = 8'h28;
  localparam logic [7:0] OFF_STAT   = 8'h2C;

  localparam int EV_SEC0  = 0;
  localparam int EV_SEC1  = 1;
  localparam int EV_MS    = 2;
  localparam int EV_CDSEC = 3;
  localparam int EV_CDMS  = 4;

  typedef logic [NSRC-1:0] ev_vec_t;
endpackage

// File: rtl/rtc_slow_tick.sv
module rtc_slow_tick #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int MS_PER_SEC    = 1000,
  parameter int COPY_TICKS    = 8,
  parameter int COPY_CYC      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_clk_i,
  output logic ms_step_o,
  output logic copy_o,
  output logic busy_o
);
  localparam int ACC_W = $clog2(TICKS_PER_SEC + MS_PER_SEC) + 1;
  localparam int PH_W  = (COPY_TICKS > 1) ? $clog2(COPY_TICKS) : 1;
  localparam int BC_W  = $clog2(COPY_CYC + 1);

  logic [2:0]       sync_q;
  logic             tick;
  logic [ACC_W-1:0] acc_q, acc_sum;
  logic [PH_W-1:0]  ph_q;
  logic [BC_W-1:0]  bcnt_q;

  assign tick      = sync_q[1] & ~sync_q[2];
  assign acc_sum   = acc_q + ACC_W'(MS_PER_SEC);
  assign ms_step_o = tick && (acc_sum >= ACC_W'(TICKS_PER_SEC));
  assign copy_o    = tick && (ph_q == PH_W'(COPY_TICKS - 1));
  assign busy_o    = (bcnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      acc_q  <= '0;
      ph_q   <= '0;
      bcnt_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], slow_clk_i};
      if (tick) begin
        acc_q <= ms_step_o ? acc_sum - ACC_W'(TICKS_PER_SEC) : acc_sum;
        ph_q  <= copy_o ? '0 : ph_q + 1'b1;
      end
      if (copy_o)      bcnt_q <= BC_W'(COPY_CYC);
      else if (busy_o) bcnt_q <= bcnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_time_count.sv
module rtc_time_count #(
  parameter int SEC_W      = 32,
  parameter int MS_PER_SEC = 1000,
  parameter int MS_W       = $clog2(MS_PER_SEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_step_i,
  input  logic             copy_i,
  input  logic             sec_wr_i,
  input  logic [SEC_W-1:0] sec_wdata_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [MS_W-1:0]  ms_o,
  output logic [SEC_W-1:0] pub_sec_o,
  output logic [MS_W-1:0]  pub_ms_o,
  output logic             carry_o
);
  logic [SEC_W-1:0] sec_q, pub_sec_q;
  logic [MS_W-1:0]  ms_q, pub_ms_q;

  assign carry_o   = ms_step_i && (ms_q == MS_W'(MS_PER_SEC - 1));
  assign sec_o     = sec_q;
  assign ms_o      = ms_q;
  assign pub_sec_o = pub_sec_q;
  assign pub_ms_o  = pub_ms_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q     <= '0;
      ms_q      <= '0;
      pub_sec_q <= '0;
      pub_ms_q  <= '0;
    end else begin
      if (ms_step_i) ms_q <= carry_o ? '0 : ms_q + 1'b1;
      if (sec_wr_i)     sec_q <= sec_wdata_i;
      else if (carry_o) sec_q <= sec_q + 1'b1;
      if (sec_wr_i)     pub_sec_q <= sec_wdata_i;
      else if (copy_i)  pub_sec_q <= sec_q;
      if (copy_i)       pub_ms_q <= ms_q;
    end
  end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_pkg::*;
#(
  parameter int SEC_W      = 32,
  parameter int MS_PER_SEC = 1000,
  parameter int MS_W       = $clog2(MS_PER_SEC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ms_step_i,
  input  logic                  carry_i,
  input  logic                  sec_wr_i,
  input  logic [SEC_W-1:0]      sec_i,
  input  logic [MS_W-1:0]       ms_i,
  input  logic                  cdn_sec_i,
  input  logic                  cdn_ms_i,
  input  logic [1:0]            wr_cmp_i,
  input  logic                  wr_cmpms_i,
  input  logic                  wr_mask_i,
  input  ev_vec_t               clr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [1:0][SEC_W-1:0] cmp_o,
  output logic [MS_W-1:0]       cmpms_o,
  output ev_vec_t               mask_o,
  output ev_vec_t               status_o,
  output logic                  irq_o
);
  logic [1:0]      sec_hit;
  logic            ms_hit;
  logic [MS_W-1:0] ms_next;
  logic [MS_W-1:0] cmpms_q;
  ev_vec_t         mask_q, stat_q, set_vec;

  for (genvar g = 0; g < 2; g++) begin : g_seccmp
    logic [SEC_W-1:0] cmp_q;
    assign sec_hit[g] = carry_i && !sec_wr_i && (cmp_q != '0) &&
                        ((sec_i + 1'b1) == cmp_q);
    assign cmp_o[g] = cmp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cmp_q <= '0;
      else if (wr_cmp_i[g]) cmp_q <= wdata_i[SEC_W-1:0];
    end
  end

  assign ms_next = carry_i ? '0 : ms_i + 1'b1;
  assign ms_hit  = ms_step_i && (cmpms_q != '0) && (ms_next == cmpms_q);

  always_comb begin
    set_vec            = '0;
    set_vec[EV_SEC0]   = sec_hit[0];
    set_vec[EV_SEC1]   = sec_hit[1];
    set_vec[EV_MS]     = ms_hit;
    set_vec[EV_CDSEC]  = cdn_sec_i;
    set_vec[EV_CDMS]   = cdn_ms_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpms_q <= '0;
      mask_q  <= '0;
      stat_q  <= '0;
    end else begin
      if (wr_cmpms_i) cmpms_q <= wdata_i[MS_W-1:0];
      if (wr_mask_i)  mask_q  <= wdata_i[NSRC-1:0];
      stat_q <= (stat_q & ~clr_i) | set_vec;
    end
  end

  assign cmpms_o  = cmpms_q;
  assign mask_o   = mask_q;
  assign status_o = stat_q;
  assign irq_o    = |(stat_q & mask_q);
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int SEC_W         = 32,
  parameter int TICKS_PER_SEC = 32768,
  parameter int MS_PER_SEC    = 1000,
  parameter int COPY_TICKS    = 8,
  parameter int COPY_CYC      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              cdn_sec_i,
  input  logic              cdn_ms_i,
  output logic              irq_o
);
  localparam int MS_W = $clog2(MS_PER_SEC);

  logic                  ms_step, copy, busy, carry;
  logic [SEC_W-1:0]      sec_live, pub_sec, snap_q;
  logic [MS_W-1:0]       ms_live, pub_ms, cmpms;
  logic [1:0][SEC_W-1:0] cmp;
  ev_vec_t               mask, status, stat_clr;
  logic                  acc, wr, rd;
  logic [7:0]            off;
  logic [DATA_W-1:0]     rd_mux;

  assign req_ready_o = !(req_write_i && busy);
  assign acc         = req_valid_i && req_ready_o;
  assign wr          = acc && req_write_i;
  assign rd          = acc && !req_write_i;
  assign off         = 8'(req_addr_i);
  assign stat_clr    = (wr && off == OFF_STAT) ? req_wdata_i[NSRC-1:0] : '0;

  rtc_slow_tick #(
    .TICKS_PER_SEC(TICKS_PER_SEC), .MS_PER_SEC(MS_PER_SEC),
    .COPY_TICKS(COPY_TICKS), .COPY_CYC(COPY_CYC)
  ) u_tick (
    .clk(clk), .rst_n(rst_n), .slow_clk_i(slow_clk_i),
    .ms_step_o(ms_step), .copy_o(copy), .busy_o(busy)
  );

  rtc_time_count #(.SEC_W(SEC_W), .MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)) u_count (
    .clk(clk), .rst_n(rst_n), .ms_step_i(ms_step), .copy_i(copy),
    .sec_wr_i(wr && off == OFF_SEC), .sec_wdata_i(req_wdata_i[SEC_W-1:0]),
    .sec_o(sec_live), .ms_o(ms_live), .pub_sec_o(pub_sec), .pub_ms_o(pub_ms),
    .carry_o(carry)
  );

  rtc_alarm_irq #(.SEC_W(SEC_W), .MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .ms_step_i(ms_step), .carry_i(carry),
    .sec_wr_i(wr && off == OFF_SEC), .sec_i(sec_live), .ms_i(ms_live),
    .cdn_sec_i(cdn_sec_i), .cdn_ms_i(cdn_ms_i),
    .wr_cmp_i({wr && off == OFF_CMP1, wr && off == OFF_CMP0}),
    .wr_cmpms_i(wr && off == OFF_CMPMS), .wr_mask_i(wr && off == OFF_MASK),
    .clr_i(stat_clr), .wdata_i(req_wdata_i),
    .cmp_o(cmp), .cmpms_o(cmpms), .mask_o(mask), .status_o(status), .irq_o(irq_o)
  );

  always_comb begin
    case (off)
      OFF_BUSY:  rd_mux = DATA_W'(busy);
      OFF_SEC:   rd_mux = DATA_W'(pub_sec);
      OFF_SNAP:  rd_mux = DATA_W'(snap_q);
      OFF_MS:    rd_mux = DATA_W'(pub_ms);
      OFF_CMP0:  rd_mux = DATA_W'(cmp[0]);
      OFF_CMP1:  rd_mux = DATA_W'(cmp[1]);
      OFF_CMPMS: rd_mux = DATA_W'(cmpms);
      OFF_MASK:  rd_mux = DATA_W'(mask);
      OFF_STAT:  rd_mux = DATA_W'(status);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd;
      if (rd) rsp_rdata_o <= rd_mux;
      if (rd && off == OFF_MS) snap_q <= pub_sec;
    end
  end
endmodule

// File: rtl/rtc_timekeeper_chk.sv
module rtc_timekeeper_chk #(
  parameter int MS_PER_SEC = 1000,
  parameter int MS_W       = $clog2(MS_PER_SEC),
  parameter int NSRC       = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_write,
  input logic            rsp_valid,
  input logic            busy,
  input logic [MS_W-1:0] ms_cnt,
  input logic [NSRC-1:0] status,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] stat_clr,
  input logic            irq
);
  AST_WR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && busy) |-> !req_ready); // R3
  AST_RD_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> req_ready); // R3
  AST_RSP_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid); // R12
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && !req_write) |=> !rsp_valid); // R12
  AST_MS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ms_cnt < MS_W'(MS_PER_SEC)); // R5
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~stat_clr) != '0) |=> ((($past(status) & ~$past(stat_clr)) & ~status) == '0)); // R10
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != '0 && status != '0)); // R11
endmodule

bind rtc_timekeeper rtc_timekeeper_chk #(.MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W), .NSRC(rtc_pkg::NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid_i), .req_ready(req_ready_o),
  .req_write(req_write_i), .rsp_valid(rsp_valid_o), .busy(busy), .ms_cnt(ms_live),
  .status(status), .mask(mask), .stat_clr(stat_clr), .irq(irq_o)
);

// File: tb/test_rtc_timekeeper.sv
`timescale 1ns/1ps
module test_rtc_timekeeper;
  localparam int TPS = 40, MSP = 10, CT = 8, CC = 3;

  logic clk = 0, rst_n = 0, slow_clk = 0, slow_en = 0;
  logic req_valid = 0, req_write = 0, cdn_sec = 0, cdn_ms = 0;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;
  int total = 0, bad = 0;
  logic done = 0;

  always #5 clk = ~clk;

  rtc_timekeeper #(.ADDR_W(8), .SEC_W(32), .TICKS_PER_SEC(TPS), .MS_PER_SEC(MSP),
                   .COPY_TICKS(CT), .COPY_CYC(CC)) i_rtc_timekeeper (
    .clk(clk), .rst_n(rst_n), .slow_clk_i(slow_clk), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .cdn_sec_i(cdn_sec), .cdn_ms_i(cdn_ms), .irq_o(irq)
  );

  initial forever begin
    repeat (2) @(negedge clk);
    if (slow_en) slow_clk = ~slow_clk;
  end

  // behavioural reference model
  bit m_s1, m_s2, m_s3, m_rspv;
  int m_acc, m_phase, m_busy, m_ms, m_pub_ms, m_alms;
  bit [31:0] m_sec, m_pub_sec, m_snap, m_al0, m_al1, m_rsp;
  bit [4:0] m_mask, m_stat;
  bit [7:0] m_rsp_addr;

  function automatic string tag_of(bit [7:0] a);
    case (a)
      8'h04: return "R2";  8'h08: return "R6";  8'h0C: return "R4";
      8'h10: return "R5";  8'h14, 8'h18: return "R7"; 8'h1C: return "R8";
      8'h28: return "R11"; 8'h2C: return "R10"; default: return "R12";
    endcase
  endfunction

  always @(posedge clk) begin
    bit tick, ok, wr, rd, step, copy, secwr;
    bit [31:0] o_sec, o_pub;
    int o_ms;
    bit [4:0] set, clr;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_rspv = 0; m_acc = 0; m_phase = 0; m_busy = 0;
      m_ms = 0; m_pub_ms = 0; m_alms = 0; m_sec = 0; m_pub_sec = 0; m_snap = 0;
      m_al0 = 0; m_al1 = 0; m_rsp = 0; m_mask = 0; m_stat = 0;
    end else begin
      tick = m_s2 && !m_s3; m_s3 = m_s2; m_s2 = m_s1; m_s1 = slow_clk;
      ok = req_valid && !(req_write && m_busy > 0);
      wr = ok && req_write; rd = ok && !req_write;
      o_sec = m_sec; o_ms = m_ms; o_pub = m_pub_sec;
      m_rspv = rd;
      if (rd) begin
        m_rsp_addr = req_addr;
        case (req_addr)
          8'h04: m_rsp = {31'b0, m_busy > 0};
          8'h08: m_rsp = m_pub_sec;
          8'h0C: m_rsp = m_snap;
          8'h10: m_rsp = m_pub_ms;
          8'h14: m_rsp = m_al0;
          8'h18: m_rsp = m_al1;
          8'h1C: m_rsp = m_alms;
          8'h28: m_rsp = {27'b0, m_mask};
          8'h2C: m_rsp = {27'b0, m_stat};
          default: m_rsp = 0;
        endcase
        if (req_addr == 8'h10) m_snap = o_pub;
      end
      step = 0; copy = 0;
      if (tick) begin
        m_acc += MSP;
        if (m_acc >= TPS) begin m_acc -= TPS; step = 1; end
        copy = (m_phase == CT - 1);
        m_phase = (m_phase + 1) % CT;
      end
      secwr = wr && req_addr == 8'h08;
      set = 0;
      if (step) begin
        if (o_ms == MSP - 1) begin
          m_ms = 0;
          if (!secwr) begin
            m_sec = o_sec + 1;
            if (m_al0 != 0 && m_sec == m_al0) set[0] = 1;
            if (m_al1 != 0 && m_sec == m_al1) set[1] = 1;
          end
        end else m_ms = o_ms + 1;
        if (m_alms != 0 && m_ms == m_alms) set[2] = 1;
      end
      if (cdn_sec) set[3] = 1;
      if (cdn_ms) set[4] = 1;
      if (secwr) begin m_sec = req_wdata; m_pub_sec = req_wdata; end
      else if (copy) m_pub_sec = o_sec;
      if (copy) m_pub_ms = o_ms;
      if (copy) m_busy = CC; else if (m_busy > 0) m_busy--;
      clr = (wr && req_addr == 8'h2C) ? req_wdata[4:0] : 5'b0;
      m_stat = (m_stat & ~clr) | set;
      if (wr && req_addr == 8'h14) m_al0 = req_wdata;
      if (wr && req_addr == 8'h18) m_al1 = req_wdata;
      if (wr && req_addr == 8'h1C) m_alms = int'(req_wdata[3:0]);
      if (wr && req_addr == 8'h28) m_mask = req_wdata[4:0];
    end
  end

  task automatic check(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(rsp_valid == m_rspv, "R12", "rsp_valid", rsp_valid, m_rspv);
      if (m_rspv) check(rsp_rdata == m_rsp, tag_of(m_rsp_addr), "read data", rsp_rdata, m_rsp);
      check(irq == |(m_stat & m_mask), "R11", "irq", irq, |(m_stat & m_mask));
      check(req_ready == !(req_write && m_busy > 0), "R3", "ready", req_ready, !(req_write && m_busy > 0));
    end
  end

  task automatic bus(input bit w, input bit [7:0] a, input bit [31:0] d, output bit [31:0] q);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    req_valid = 0; req_write = 0;
    q = rsp_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    bit [31:0] q;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    check(irq == 0, "R1", "irq after reset", irq, 0);
    for (int i = 1; i <= 11; i++) begin
      bus(0, 8'(i * 4), 0, q);
      check(q == 0, "R1", "register after reset", q, 0);
    end
    slow_en = 1;
    for (int i = 0; i < 40; i++) begin
      bus(0, 8'h10, 0, q); bus(0, 8'h0C, 0, q); bus(0, 8'h04, 0, q);
      idle(i % 7);
    end
    for (int i = 0; i < 12; i++) begin
      bus(1, 8'h08, 32'd100, q); // R6 write, often collides with busy (R3)
      bus(0, 8'h08, 0, q);
      idle(i);
    end
    bus(1, 8'h14, 32'd102, q);
    bus(1, 8'h18, 32'd103, q);
    bus(1, 8'h28, 32'h1, q);
    idle(500);
    bus(0, 8'h2C, 0, q);
    check(q[0] == 1, "R7", "cmp0 status", q[0], 1);
    check(q[1] == 1, "R11", "unmasked source still sets", q[1], 1);
    bus(1, 8'h2C, 32'h0, q);
    bus(0, 8'h2C, 0, q);
    check(q[0] == 1, "R10", "write 0 keeps bit", q[0], 1);
    bus(1, 8'h2C, 32'h1, q);
    bus(0, 8'h2C, 0, q);
    check(q[0] == 0, "R10", "write 1 clears bit", q[0], 0);
    bus(1, 8'h1C, 32'd5, q);
    bus(1, 8'h28, 32'h4, q);
    idle(200);
    bus(0, 8'h2C, 0, q);
    check(q[2] == 1, "R8", "sub-second cmp status", q[2], 1);
    bus(1, 8'h2C, 32'h1F, q);
    bus(1, 8'h1C, 32'd0, q);
    bus(1, 8'h14, 32'd0, q);
    bus(1, 8'h18, 32'd0, q);
    bus(1, 8'h28, 32'h18, q);
    @(negedge clk); cdn_sec = 1; @(negedge clk); cdn_sec = 0; cdn_ms = 1;
    @(negedge clk); cdn_ms = 0;
    bus(0, 8'h2C, 0, q);
    check(q == 32'h18, "R9", "countdown strobes", q, 32'h18);
    bus(1, 8'h2C, 32'h1F, q);
    bus(1, 8'h08, 32'hFFFF_FFFF, q);
    idle(400);
    bus(0, 8'h2C, 0, q);
    check(q[0] == 0, "R7", "zero compare never fires", q[0], 0);
    bus(1, 8'h30, 32'hFFFF_FFFF, q);
    bus(1, 8'h0C, 32'h55, q);
    bus(0, 8'h30, 0, q);
    check(q == 0, "R12", "unmapped read", q, 0);
    for (int i = 0; i < 30; i++) begin
      bus(0, 8'h10, 0, q); bus(0, 8'h0C, 0, q); bus(0, 8'h08, 0, q);
      idle(3);
    end
    idle(20);
    finish_run();
  end

  initial begin
    repeat (60000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end
endmodule